// File: doc/BRIEF.md
# IDE Port Access Decoder

This block sits between a host I/O bus and one IDE channel. It takes a single access, made of a window select, an offset, a width code, read and write strobes and write data, and turns it into at most one register operation toward the drive. The block is purely combinational, with no wait states: strobes and read data follow the inputs within the same cycle. There are two windows. The command window holds the byte-wide task-file registers and the data port. The control window holds one register: alternate status when read, device control when written.

The width decides where an access goes. A byte access reaches any task-file register. A 2-byte or 4-byte access works only at offset 0 of the command window, where it becomes a 16-bit or 32-bit data-port transfer. Every other combination is not decoded. A read of an undecoded access returns all ones across the access width, and a write to one is dropped. Data is little-endian, so byte and halfword values sit in the low lanes of the 32-bit buses.

Top module: `ide_port_decoder`

## Requirements
- R1: A command-window (win_i=0) access with size_i=0 (1 byte) at offset N raises reg_rd_o or reg_wr_o with reg_bank_o=0 and reg_idx_o=N. A read returns reg_rdata_i in rdata_o[7:0] with the upper bits zero, and a write drives wdata_i[7:0] on reg_wdata_o.
- R2: A command-window access with size_i=1 (2 bytes) at offset 0 raises dp16_rd_o or dp16_wr_o. A read returns dp_rdata_i[15:0] zero-extended, and a write drives dp_wdata_o as wdata_i[15:0] zero-extended.
- R3: A command-window access with size_i=2 (4 bytes) at offset 0 raises dp32_rd_o or dp32_wr_o. A read returns dp_rdata_i, and a write drives dp_wdata_o with wdata_i.
- R4: A command-window access with size_i=1 or 2 at a nonzero offset raises no strobe. A read returns 32'h0000FFFF for 2 bytes and 32'hFFFFFFFF for 4 bytes.
- R5: A control-window (win_i=1) access with size_i=0 at offset 2 raises reg_rd_o (alternate status) or reg_wr_o (device control) with reg_bank_o=1 and reg_idx_o=4, which is the offset plus 2.
- R6: Any other control-window access raises no strobe. A read returns all ones across the access width (32'h000000FF, 32'h0000FFFF or 32'hFFFFFFFF).
- R7: With neither rd_i nor wr_i set, no strobe is raised and rdata_o is 0. No access raises more than one strobe. If rd_i and wr_i are both set, the access is a write only.
- R8: size_i=3 is reserved. It raises no strobe in either window, and a read returns 32'hFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| win_i | input | 1 | Window select: 0 command, 1 control |
| rd_i | input | 1 | Read access |
| wr_i | input | 1 | Write access |
| off_i | input | 3 | Byte offset within the window |
| size_i | input | 2 | Width code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| wdata_i | input | 32 | Host write data, little-endian |
| rdata_o | output | 32 | Host read data |
| reg_rd_o | output | 1 | Byte register read strobe |
| reg_wr_o | output | 1 | Byte register write strobe |
| reg_bank_o | output | 1 | Register bank: 0 task file, 1 control |
| reg_idx_o | output | 3 | Register index presented to the drive |
| reg_wdata_o | output | 8 | Byte register write data |
| reg_rdata_i | input | 8 | Byte register read data |
| dp16_rd_o | output | 1 | 16-bit data-port read strobe |
| dp16_wr_o | output | 1 | 16-bit data-port write strobe |
| dp32_rd_o | output | 1 | 32-bit data-port read strobe |
| dp32_wr_o | output | 1 | 32-bit data-port write strobe |
| dp_wdata_o | output | 32 | Data-port write data |
| dp_rdata_i | input | 32 | Data-port read data |

## Verification
The bench builds the decoder with its default parameters: a 3-bit offset, a 32-bit data bus, control register offset 2 and an index bias of 2. With a 3-bit offset, every task-file index from 0 to 7 is reachable. With four byte lanes, all-ones fills of 1, 2 and 4 bytes can be told apart. The bench ties reg_rdata_i to a value built from reg_bank_o and reg_idx_o, so the read data also shows which bank and index the decoder selected, including the biased control index 4.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_REG  = 2'd1,
    HIT_DP16 = 2'd2,
    HIT_DP32 = 2'd3
  } hit_e;
endpackage

// File: rtl/ide_cmd_decode.sv
module ide_cmd_decode
  import ide_dec_pkg::*;
#(
  parameter int OFF_W = 3
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output hit_e             hit_o
);
  logic at_base;
  assign at_base = (off_i == '0);

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: hit_o = HIT_REG;
      SZ_HALF: hit_o = at_base ? HIT_DP16 : HIT_NONE;
      SZ_WORD: hit_o = at_base ? HIT_DP32 : HIT_NONE;
      default: hit_o = HIT_NONE;
    endcase
  end
endmodule

// File: rtl/ide_ctl_decode.sv
module ide_ctl_decode
  import ide_dec_pkg::*;
#(
  parameter int OFF_W        = 3,
  parameter int CTL_OFF      = 2,
  parameter int CTL_IDX_BIAS = 2
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output hit_e             hit_o,
  output logic [OFF_W-1:0] idx_o
);
  localparam logic [OFF_W-1:0] HitOff = OFF_W'(CTL_OFF);
  localparam logic [OFF_W-1:0] Bias   = OFF_W'(CTL_IDX_BIAS);

  // drive sees the control register shifted past the command-side index
  assign idx_o = off_i + Bias;
  assign hit_o = ((off_i == HitOff) && (acc_size_e'(size_i) == SZ_BYTE)) ? HIT_REG : HIT_NONE;
endmodule

// File: rtl/ide_lane_mask.sv
module ide_lane_mask
  import ide_dec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] mask_o
);
  localparam int LANES = DATA_W / 8;

  logic [7:0] nbytes;

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: nbytes = 8'd1;
      SZ_HALF: nbytes = 8'd2;
      SZ_WORD: nbytes = 8'd4;
      default: nbytes = 8'(LANES);
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask_o[g*8 +: 8] = {8{8'(g) < nbytes}};
  end
endmodule

// File: rtl/ide_port_decoder.sv
module ide_port_decoder
  import ide_dec_pkg::*;
#(
  parameter int OFF_W        = 3,
  parameter int DATA_W       = 32,
  parameter int CTL_OFF      = 2,
  parameter int CTL_IDX_BIAS = 2
) (
  input  logic              win_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic              reg_bank_o,
  output logic [OFF_W-1:0]  reg_idx_o,
  output logic [7:0]        reg_wdata_o,
  input  logic [7:0]        reg_rdata_i,
  output logic              dp16_rd_o,
  output logic              dp16_wr_o,
  output logic              dp32_rd_o,
  output logic              dp32_wr_o,
  output logic [DATA_W-1:0] dp_wdata_o,
  input  logic [DATA_W-1:0] dp_rdata_i
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  hit_e             cmd_hit, ctl_hit, hit;
  logic [OFF_W-1:0] ctl_idx;
  logic [DATA_W-1:0] ones_mask;
  logic             rd_eff, wr_eff;

  ide_cmd_decode #(.OFF_W(OFF_W)) u_cmd (
    .off_i  (off_i),
    .size_i (size_i),
    .hit_o  (cmd_hit)
  );

  ide_ctl_decode #(
    .OFF_W        (OFF_W),
    .CTL_OFF      (CTL_OFF),
    .CTL_IDX_BIAS (CTL_IDX_BIAS)
  ) u_ctl (
    .off_i  (off_i),
    .size_i (size_i),
    .hit_o  (ctl_hit),
    .idx_o  (ctl_idx)
  );

  ide_lane_mask #(.DATA_W(DATA_W)) u_mask (
    .size_i (size_i),
    .mask_o (ones_mask)
  );

  // write wins when both strobes arrive together
  assign wr_eff = wr_i;
  assign rd_eff = rd_i & ~wr_i;
  assign hit    = win_i ? ctl_hit : cmd_hit;

  assign reg_rd_o    = rd_eff && (hit == HIT_REG);
  assign reg_wr_o    = wr_eff && (hit == HIT_REG);
  assign dp16_rd_o   = rd_eff && (hit == HIT_DP16);
  assign dp16_wr_o   = wr_eff && (hit == HIT_DP16);
  assign dp32_rd_o   = rd_eff && (hit == HIT_DP32);
  assign dp32_wr_o   = wr_eff && (hit == HIT_DP32);
  assign reg_bank_o  = win_i;
  assign reg_idx_o   = win_i ? ctl_idx : off_i;
  assign reg_wdata_o = wdata_i[BYTE_W-1:0];

  always_comb begin
    if (hit == HIT_DP16) dp_wdata_o = {{(DATA_W-HALF_W){1'b0}}, wdata_i[HALF_W-1:0]};
    else                 dp_wdata_o = wdata_i;
  end

  always_comb begin
    if (!rd_eff) begin
      rdata_o = '0;
    end else begin
      unique case (hit)
        HIT_REG:  rdata_o = {{(DATA_W-BYTE_W){1'b0}}, reg_rdata_i};
        HIT_DP16: rdata_o = {{(DATA_W-HALF_W){1'b0}}, dp_rdata_i[HALF_W-1:0]};
        HIT_DP32: rdata_o = dp_rdata_i;
        default:  rdata_o = ones_mask;
      endcase
    end
  end
endmodule

// File: rtl/ide_port_decoder_chk.sv
module ide_port_decoder_chk #(
  parameter int OFF_W        = 3,
  parameter int DATA_W       = 32,
  parameter int CTL_OFF      = 2,
  parameter int CTL_IDX_BIAS = 2
) (
  input logic              win_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [OFF_W-1:0]  off_i,
  input logic [1:0]        size_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              reg_rd_o,
  input logic              reg_wr_o,
  input logic              reg_bank_o,
  input logic [OFF_W-1:0]  reg_idx_o,
  input logic              dp16_rd_o,
  input logic              dp16_wr_o,
  input logic              dp32_rd_o,
  input logic              dp32_wr_o
);
  logic [5:0] strobes;
  assign strobes = {reg_rd_o, reg_wr_o, dp16_rd_o, dp16_wr_o, dp32_rd_o, dp32_wr_o};

  always_comb begin
    p_one_strobe_r7: assert ($countones(strobes) <= 1)
      else $error("more than one strobe");
    if (!rd_i && !wr_i) begin
      p_idle_quiet_r7: assert (strobes == '0 && rdata_o == '0)
        else $error("activity while idle");
    end
    if (!win_i && size_i != 2'd0 && off_i != '0) begin
      p_wide_offset_r4: assert (strobes == '0)
        else $error("wide access at nonzero offset decoded");
    end
    if (win_i && (reg_rd_o || reg_wr_o)) begin
      p_ctl_index_r5: assert (off_i == OFF_W'(CTL_OFF) && size_i == 2'd0 && reg_bank_o
                              && reg_idx_o == OFF_W'(CTL_OFF + CTL_IDX_BIAS))
        else $error("control strobe on bad access");
    end
    if (dp16_rd_o || dp16_wr_o) begin
      p_dp16_base_r2: assert (!win_i && off_i == '0 && size_i == 2'd1)
        else $error("16-bit data port strobe misplaced");
    end
    if (win_i && rd_i && !wr_i && size_i == 2'd0 && off_i != OFF_W'(CTL_OFF)) begin
      p_ctl_miss_ones_r6: assert (rdata_o == DATA_W'(8'hFF))
        else $error("control miss read not all ones");
    end
    if (size_i == 2'd3) begin
      p_rsvd_quiet_r8: assert (strobes == '0)
        else $error("reserved size decoded");
    end
  end
endmodule

bind ide_port_decoder ide_port_decoder_chk #(
  .OFF_W        (OFF_W),
  .DATA_W       (DATA_W),
  .CTL_OFF      (CTL_OFF),
  .CTL_IDX_BIAS (CTL_IDX_BIAS)
) u_chk (.*);

// File: tb/tb_ide_port_decoder.sv
module tb_ide_port_decoder;
  localparam int OFF_W  = 3;
  localparam int DATA_W = 32;
  localparam logic [31:0] DP_VAL = 32'h1234_5678;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              win, rd, wr;
  logic [OFF_W-1:0]  off;
  logic [1:0]        sz;
  logic [DATA_W-1:0] wdata, rdata, dp_wdata;
  logic              reg_rd, reg_wr, reg_bank;
  logic [OFF_W-1:0]  reg_idx;
  logic [7:0]        reg_wdata, reg_rdata;
  logic              dp16_rd, dp16_wr, dp32_rd, dp32_wr;

  // register model: value shows which bank and index were selected
  assign reg_rdata = {reg_bank, 4'hA, reg_idx};

  ide_port_decoder dut (
    .win_i(win), .rd_i(rd), .wr_i(wr), .off_i(off), .size_i(sz),
    .wdata_i(wdata), .rdata_o(rdata),
    .reg_rd_o(reg_rd), .reg_wr_o(reg_wr), .reg_bank_o(reg_bank),
    .reg_idx_o(reg_idx), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata),
    .dp16_rd_o(dp16_rd), .dp16_wr_o(dp16_wr), .dp32_rd_o(dp32_rd),
    .dp32_wr_o(dp32_wr), .dp_wdata_o(dp_wdata), .dp_rdata_i(DP_VAL)
  );

  typedef struct packed {
    logic        win;
    logic        rd;
    logic        wr;
    logic [2:0]  off;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic [1:0]  kind;   // 0 none, 1 reg, 2 dp16, 3 dp32
    logic        bank;
    logic [2:0]  idx;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t TBL [NVEC] = '{
    '{1'b0,1'b1,1'b0,3'd0,2'd0,32'h0,        32'h0000_0050,2'd1,1'b0,3'd0,4'd1}, // R1
    '{1'b0,1'b1,1'b0,3'd7,2'd0,32'h0,        32'h0000_0057,2'd1,1'b0,3'd7,4'd1}, // R1
    '{1'b0,1'b0,1'b1,3'd3,2'd0,32'hC3,       32'h0,        2'd1,1'b0,3'd3,4'd1}, // R1
    '{1'b0,1'b1,1'b0,3'd0,2'd1,32'h0,        32'h0000_5678,2'd2,1'b0,3'd0,4'd2}, // R2
    '{1'b0,1'b1,1'b0,3'd0,2'd2,32'h0,        32'h1234_5678,2'd3,1'b0,3'd0,4'd3}, // R3
    '{1'b0,1'b1,1'b0,3'd1,2'd1,32'h0,        32'h0000_FFFF,2'd0,1'b0,3'd0,4'd4}, // R4
    '{1'b0,1'b1,1'b0,3'd4,2'd2,32'h0,        32'hFFFF_FFFF,2'd0,1'b0,3'd0,4'd4}, // R4
    '{1'b0,1'b0,1'b1,3'd2,2'd1,32'hBEEF,     32'h0,        2'd0,1'b0,3'd0,4'd4}, // R4
    '{1'b1,1'b1,1'b0,3'd2,2'd0,32'h0,        32'h0000_00D4,2'd1,1'b1,3'd4,4'd5}, // R5
    '{1'b1,1'b0,1'b1,3'd2,2'd0,32'h0E,       32'h0,        2'd1,1'b1,3'd4,4'd5}, // R5
    '{1'b1,1'b1,1'b0,3'd0,2'd0,32'h0,        32'h0000_00FF,2'd0,1'b0,3'd0,4'd6}, // R6
    '{1'b1,1'b1,1'b0,3'd2,2'd1,32'h0,        32'h0000_FFFF,2'd0,1'b0,3'd0,4'd6}, // R6
    '{1'b1,1'b1,1'b0,3'd0,2'd2,32'h0,        32'hFFFF_FFFF,2'd0,1'b0,3'd0,4'd6}, // R6
    '{1'b1,1'b0,1'b1,3'd3,2'd0,32'h55,       32'h0,        2'd0,1'b0,3'd0,4'd6}, // R6
    '{1'b0,1'b1,1'b0,3'd0,2'd3,32'h0,        32'hFFFF_FFFF,2'd0,1'b0,3'd0,4'd8}  // R8
  };

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  // observed strobe code: {is_write, kind}; 7 means several strobes
  function automatic logic [2:0] obs_code();
    int n;
    logic [2:0] c;
    n = int'(reg_rd) + int'(reg_wr) + int'(dp16_rd) + int'(dp16_wr) + int'(dp32_rd) + int'(dp32_wr);
    c = 3'd0;
    if (reg_rd)  c = 3'b001;
    if (reg_wr)  c = 3'b101;
    if (dp16_rd) c = 3'b010;
    if (dp16_wr) c = 3'b110;
    if (dp32_rd) c = 3'b011;
    if (dp32_wr) c = 3'b111;
    if (n > 1)   c = 3'b111;
    return c;
  endfunction

  task automatic drive(input logic w, input logic r, input logic wv, input logic [2:0] o,
                       input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    win = w; rd = r; wr = wv; off = o; sz = s; wdata = d;
    #1;
  endtask

  initial begin
    win = 0; rd = 0; wr = 0; off = 0; sz = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R7: idle state, no strobe, zero read data
    check("R7", "idle strobes", 32'(obs_code()), 32'd0);
    check("R7", "idle rdata", rdata, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      string rq;
      logic [2:0] exp_code;
      rq = $sformatf("R%0d", TBL[i].req);
      drive(TBL[i].win, TBL[i].rd, TBL[i].wr, TBL[i].off, TBL[i].sz, TBL[i].wd);
      exp_code = {TBL[i].wr && TBL[i].kind != 2'd0, TBL[i].kind};
      check(rq, $sformatf("vec %0d strobe", i), 32'(obs_code()), 32'(exp_code));
      check(rq, $sformatf("vec %0d rdata", i), rdata, TBL[i].exp_rd);
      if (TBL[i].kind == 2'd1)
        check(rq, $sformatf("vec %0d bank/idx", i), {28'h0, reg_bank, reg_idx},
              {28'h0, TBL[i].bank, TBL[i].idx});
    end

    // R1: byte write data on low lane
    drive(1'b0, 1'b0, 1'b1, 3'd5, 2'd0, 32'hAABB_CC3C);
    check("R1", "reg wdata", 32'(reg_wdata), 32'h3C);
    // R2: 16-bit write data zero-extended
    drive(1'b0, 1'b0, 1'b1, 3'd0, 2'd1, 32'hDEAD_BEEF);
    check("R2", "dp16 wdata", dp_wdata, 32'h0000_BEEF);
    check("R2", "dp16 write strobe", 32'(obs_code()), 32'b110);
    // R3: 32-bit write data full width
    drive(1'b0, 1'b0, 1'b1, 3'd0, 2'd2, 32'hDEAD_BEEF);
    check("R3", "dp32 wdata", dp_wdata, 32'hDEAD_BEEF);
    // R5: device control write carries data and biased index
    drive(1'b1, 1'b0, 1'b1, 3'd2, 2'd0, 32'h0000_0006);
    check("R5", "devctl wdata", 32'(reg_wdata), 32'h06);
    check("R5", "devctl idx", 32'(reg_idx), 32'd4);
    // R7: read and write together act as a write only
    drive(1'b0, 1'b1, 1'b1, 3'd1, 2'd0, 32'h11);
    check("R7", "rd+wr strobe", 32'(obs_code()), 32'b101);
    check("R7", "rd+wr rdata", rdata, 32'h0);
    // R8: reserved size write in control window is dropped
    drive(1'b1, 1'b0, 1'b1, 3'd2, 2'd3, 32'hFF);
    check("R8", "reserved write strobe", 32'(obs_code()), 32'd0);
    // R7: back to idle
    drive(1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 32'h0);
    check("R7", "return to idle", rdata, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule